// File: doc/BRIEF.md
# Segment Register Rename Table

This block sits in the register alias stage of an out-of-order core, next to the general register renamer. It renames the four data segment registers onto reorder-buffer (ROB) entries. A micro-op that loads a segment register does not stop younger micro-ops from issuing. Instead, the table entry for that segment is pointed at the loading micro-op's ROB tag. Every younger load or store that reads the segment then gets that tag, and so waits on the real producer instead of using the stale committed value.

Up to `LANES` micro-ops (two by default) are renamed per cycle. Each lane presents a source segment index, a write flag, a destination segment index and its allocated ROB tag. For its source segment the lane gets back an alias flag and a tag. It also always gets the committed value from the architectural file, and uses that value when the alias flag is low. A micro-op in a later lane sees a segment write made by an earlier lane of the same group. Retirement writes the committed value and releases the alias when the alias still names the retiring micro-op. A flush drops every alias.

A `fence_mode` input selects the older serialising behaviour, which is kept for comparison. In that mode, once a segment load has been accepted, the renamer refuses all further micro-ops until the load's completion is reported.

The rename input is a valid/ready stream, one valid/ready pair per lane. A lane is taken in a cycle where both its valid and its ready are high. Valid lanes are packed from lane 0 upward. Once a lane is refused, every later lane in the group is refused too. The sender re-presents refused micro-ops in order, starting in lane 0 on a later cycle. Lookup results are combinational and belong to the lanes accepted in that same cycle. The output side has no back-pressure.

Top module: `seg_rename`

## Requirements
- R1: After reset no segment is aliased, every committed value is zero, `fence_stall` is low, and all lanes are ready.
- R2: An accepted micro-op with its write flag set makes its destination segment aliased to its own tag from the next cycle on. A lookup of an aliased segment returns alias=1 and that tag. A lookup of an unaliased segment returns alias=0 and tag 0.
- R3: When several accepted micro-ops write the same segment, the table keeps the tag of the newest one. Within one cycle a higher lane is younger than a lower lane.
- R4: A lane's lookup sees a write made by an accepted lower lane in the same cycle, and returns that lane's tag.
- R5: A retirement (`ret_valid`) writes `ret_value` into the committed value of `ret_seg` for the next cycle. `out_value` always returns the committed value of the source segment as it stood at the start of the cycle. A segment index is 2 bits and selects one of the four segments.
- R6: A retirement clears the alias of `ret_seg` only when the alias is set and its tag equals `ret_tag`, and only when no accepted micro-op of the same cycle writes that segment. Otherwise the alias is left as it was.
- R7: In a cycle with `flush` high, no lane is ready. From the next cycle on, every alias is clear and `fence_stall` is low. A retirement in the same cycle still updates the committed value.
- R8: In fence mode, accepting a segment write raises `fence_stall` from the next cycle. While `fence_stall` is high no lane is ready. `fence_stall` falls after a cycle with `cmpl_valid` high and `cmpl_tag` equal to that writer's tag. A completion with any other tag has no effect.
- R9: In fence mode, a lane that follows a valid segment-writing lane in the same group is not ready.
- R10: With fence mode off, `fence_stall` never rises, and every lane is ready except in a flush cycle.
- R11: `out_valid` of a lane is high exactly when that lane is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fence_mode | input | 1 | 1 selects serialising behaviour on segment loads |
| flush | input | 1 | Pipeline flush, drops all aliases |
| in_valid | input | LANES | Per-lane micro-op valid |
| in_ready | output | LANES | Per-lane accept |
| in_src_seg | input | 2*LANES | Per-lane source segment index |
| in_wr | input | LANES | Per-lane segment write flag |
| in_dst_seg | input | 2*LANES | Per-lane destination segment index |
| in_tag | input | TAG_W*LANES | Per-lane allocated ROB tag |
| out_valid | output | LANES | Per-lane lookup result valid |
| out_alias | output | LANES | Source segment is aliased to an in-flight writer |
| out_tag | output | TAG_W*LANES | Producer tag when aliased, else 0 |
| out_value | output | SEG_W*LANES | Committed value of the source segment |
| ret_valid | input | 1 | A segment-load micro-op retires |
| ret_seg | input | 2 | Segment written by the retiring micro-op |
| ret_tag | input | TAG_W | ROB tag of the retiring micro-op |
| ret_value | input | SEG_W | Value being committed |
| cmpl_valid | input | 1 | Execution completion report |
| cmpl_tag | input | TAG_W | Tag of the completing micro-op |
| fence_stall | output | 1 | Fence-mode stall in force |

## Verification
The assertions take for granted that the sender keeps valid lanes packed from lane 0 and holds the group steady while it is refused. They also take for granted that a completion for the fenced load never arrives in the cycle the load is accepted. The stimulus keeps to these rules. It draws lane 1 valid only when lane 0 is valid. It reports completions only while `fence_stall` is high. Because it builds each cycle's inputs afresh, it never relies on refused lanes being held. The random sweep mixes segment indices, write flags and tags, sometimes aiming retirements at the live tag of a segment and sometimes at another tag. It also mixes in occasional flushes and both fence settings, so same-cycle retire/rename/flush overlaps come up many times.

// File: rtl/seg_ren_pkg.sv
package seg_ren_pkg;
  localparam int NUM_SEG   = 4;
  localparam int SEG_IDX_W = $clog2(NUM_SEG);
  typedef logic [SEG_IDX_W-1:0] seg_idx_t;
endpackage

// File: rtl/seg_fence_ctl.sv
module seg_fence_ctl
  import seg_ren_pkg::*;
#(
  parameter int LANES = 2,
  parameter int TAG_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fence_mode,
  input  logic                   flush,
  input  logic [LANES-1:0]       lane_valid,
  input  logic [LANES-1:0]       lane_wr,
  input  logic [LANES*TAG_W-1:0] lane_tag,
  input  logic                   cmpl_valid,
  input  logic [TAG_W-1:0]       cmpl_tag,
  output logic [LANES-1:0]       lane_ready,
  output logic [LANES-1:0]       lane_acc,
  output logic                   stall
);
  logic             stall_q;
  logic [TAG_W-1:0] wait_tag_q;
  logic             arm;
  logic [TAG_W-1:0] arm_tag;

  // A lane is refused once any earlier lane in the group loads a segment
  // while the serialising mode is on.
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    arm     = 1'b0;
    arm_tag = '0;
    for (int i = 0; i < LANES; i++) begin
      lane_ready[i] = !stall_q && !flush && !blocked;
      lane_acc[i]   = lane_valid[i] && lane_ready[i];
      if (fence_mode && lane_valid[i] && lane_wr[i]) blocked = 1'b1;
      if (fence_mode && lane_acc[i] && lane_wr[i]) begin
        arm     = 1'b1;
        arm_tag = lane_tag[i*TAG_W +: TAG_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q    <= 1'b0;
      wait_tag_q <= '0;
    end else if (flush) begin
      stall_q    <= 1'b0;
    end else if (arm) begin
      stall_q    <= 1'b1;
      wait_tag_q <= arm_tag;
    end else if (stall_q && cmpl_valid && (cmpl_tag == wait_tag_q)) begin
      stall_q    <= 1'b0;
    end
  end

  assign stall = stall_q;
endmodule

// File: rtl/seg_arch_file.sv
module seg_arch_file
  import seg_ren_pkg::*;
#(
  parameter int LANES = 2,
  parameter int SEG_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  seg_idx_t                   wr_seg,
  input  logic [SEG_W-1:0]           wr_value,
  input  logic [LANES*SEG_IDX_W-1:0] rd_seg,
  output logic [LANES*SEG_W-1:0]     rd_value,
  output logic [NUM_SEG*SEG_W-1:0]   arch_flat
);
  logic [SEG_W-1:0] regs_q [NUM_SEG];

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        regs_q[s] <= '0;
      else if (wr_en && (wr_seg == seg_idx_t'(s)))       regs_q[s] <= wr_value;
    end
    assign arch_flat[s*SEG_W +: SEG_W] = regs_q[s];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_rd
    assign rd_value[i*SEG_W +: SEG_W] = regs_q[rd_seg[i*SEG_IDX_W +: SEG_IDX_W]];
  end
endmodule

// File: rtl/seg_alias_table.sv
module seg_alias_table
  import seg_ren_pkg::*;
#(
  parameter int LANES = 2,
  parameter int TAG_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic [LANES-1:0]           lane_acc,
  input  logic [LANES-1:0]           lane_wr,
  input  logic [LANES*SEG_IDX_W-1:0] lane_dst,
  input  logic [LANES*SEG_IDX_W-1:0] lane_src,
  input  logic [LANES*TAG_W-1:0]     lane_tag,
  input  logic                       ret_valid,
  input  seg_idx_t                   ret_seg,
  input  logic [TAG_W-1:0]           ret_tag,
  output logic [LANES-1:0]           src_alias,
  output logic [LANES*TAG_W-1:0]     src_tag,
  output logic [NUM_SEG-1:0]         alias_vld,
  output logic [NUM_SEG*TAG_W-1:0]   alias_tags
);
  logic [NUM_SEG-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [NUM_SEG];

  // Lookup: table state at cycle start, overridden by the youngest
  // accepted writer in a lower lane of the same group.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      seg_idx_t         s;
      logic             hit;
      logic [TAG_W-1:0] t;
      s   = lane_src[i*SEG_IDX_W +: SEG_IDX_W];
      hit = vld_q[s];
      t   = tag_q[s];
      for (int j = 0; j < LANES; j++) begin
        if (j < i && lane_acc[j] && lane_wr[j] &&
            lane_dst[j*SEG_IDX_W +: SEG_IDX_W] == s) begin
          hit = 1'b1;
          t   = lane_tag[j*TAG_W +: TAG_W];
        end
      end
      src_alias[i]              = hit;
      src_tag[i*TAG_W +: TAG_W] = hit ? t : '0;
    end
  end

  // Update: flush wins; otherwise a matching retire releases the entry
  // and renames (in lane order, youngest last) overwrite it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < NUM_SEG; s++) tag_q[s] <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else begin
      if (ret_valid && vld_q[ret_seg] && (tag_q[ret_seg] == ret_tag))
        vld_q[ret_seg] <= 1'b0;
      for (int j = 0; j < LANES; j++) begin
        if (lane_acc[j] && lane_wr[j]) begin
          vld_q[lane_dst[j*SEG_IDX_W +: SEG_IDX_W]] <= 1'b1;
          tag_q[lane_dst[j*SEG_IDX_W +: SEG_IDX_W]] <= lane_tag[j*TAG_W +: TAG_W];
        end
      end
    end
  end

  assign alias_vld = vld_q;
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_tags
    assign alias_tags[s*TAG_W +: TAG_W] = tag_q[s];
  end
endmodule

// File: rtl/seg_rename.sv
module seg_rename
  import seg_ren_pkg::*;
#(
  parameter int LANES = 2,
  parameter int TAG_W = 5,
  parameter int SEG_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fence_mode,
  input  logic                       flush,
  input  logic [LANES-1:0]           in_valid,
  output logic [LANES-1:0]           in_ready,
  input  logic [LANES*SEG_IDX_W-1:0] in_src_seg,
  input  logic [LANES-1:0]           in_wr,
  input  logic [LANES*SEG_IDX_W-1:0] in_dst_seg,
  input  logic [LANES*TAG_W-1:0]     in_tag,
  output logic [LANES-1:0]           out_valid,
  output logic [LANES-1:0]           out_alias,
  output logic [LANES*TAG_W-1:0]     out_tag,
  output logic [LANES*SEG_W-1:0]     out_value,
  input  logic                       ret_valid,
  input  logic [SEG_IDX_W-1:0]       ret_seg,
  input  logic [TAG_W-1:0]           ret_tag,
  input  logic [SEG_W-1:0]           ret_value,
  input  logic                       cmpl_valid,
  input  logic [TAG_W-1:0]           cmpl_tag,
  output logic                       fence_stall
);
  logic [LANES-1:0]           acc;
  logic [NUM_SEG-1:0]         alias_vld;
  logic [NUM_SEG*TAG_W-1:0]   alias_tags;
  logic [NUM_SEG*SEG_W-1:0]   arch_flat;

  seg_fence_ctl #(.LANES(LANES), .TAG_W(TAG_W)) u_fence (
    .clk        (clk),
    .rst_n      (rst_n),
    .fence_mode (fence_mode),
    .flush      (flush),
    .lane_valid (in_valid),
    .lane_wr    (in_wr),
    .lane_tag   (in_tag),
    .cmpl_valid (cmpl_valid),
    .cmpl_tag   (cmpl_tag),
    .lane_ready (in_ready),
    .lane_acc   (acc),
    .stall      (fence_stall)
  );

  seg_alias_table #(.LANES(LANES), .TAG_W(TAG_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lane_acc   (acc),
    .lane_wr    (in_wr),
    .lane_dst   (in_dst_seg),
    .lane_src   (in_src_seg),
    .lane_tag   (in_tag),
    .ret_valid  (ret_valid),
    .ret_seg    (ret_seg),
    .ret_tag    (ret_tag),
    .src_alias  (out_alias),
    .src_tag    (out_tag),
    .alias_vld  (alias_vld),
    .alias_tags (alias_tags)
  );

  seg_arch_file #(.LANES(LANES), .SEG_W(SEG_W)) u_arch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ret_valid),
    .wr_seg    (ret_seg),
    .wr_value  (ret_value),
    .rd_seg    (in_src_seg),
    .rd_value  (out_value),
    .arch_flat (arch_flat)
  );

  assign out_valid = acc;
endmodule

// File: rtl/seg_rename_chk.sv
module seg_rename_chk
  import seg_ren_pkg::*;
#(
  parameter int LANES = 2,
  parameter int TAG_W = 5,
  parameter int SEG_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fence_mode,
  input logic                       flush,
  input logic [LANES-1:0]           in_valid,
  input logic [LANES-1:0]           in_ready,
  input logic [LANES-1:0]           in_wr,
  input logic [LANES*SEG_IDX_W-1:0] in_dst_seg,
  input logic                       ret_valid,
  input logic [SEG_IDX_W-1:0]       ret_seg,
  input logic [TAG_W-1:0]           ret_tag,
  input logic [SEG_W-1:0]           ret_value,
  input logic                       fence_stall,
  input logic [NUM_SEG-1:0]         alias_vld,
  input logic [NUM_SEG*TAG_W-1:0]   alias_tags,
  input logic [NUM_SEG*SEG_W-1:0]   arch_flat
);
  logic l0_wr_acc, l1_wr_acc, same_dst, ret_hit;
  assign l0_wr_acc = in_valid[0] && in_ready[0] && in_wr[0];
  assign l1_wr_acc = in_valid[1] && in_ready[1] && in_wr[1];
  assign same_dst  = in_dst_seg[1:0] == in_dst_seg[2*SEG_IDX_W-1:SEG_IDX_W];
  assign ret_hit   = alias_tags[ret_seg*TAG_W +: TAG_W] == ret_tag;

  a_r2_alias_set: assert property (@(posedge clk) disable iff (!rst_n)
    l0_wr_acc && !(l1_wr_acc && same_dst) |=> alias_vld[$past(in_dst_seg[1:0])]);

  a_r5_commit: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> arch_flat[$past(ret_seg)*SEG_W +: SEG_W] == $past(ret_value));

  a_r6_keep_alias: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && alias_vld[ret_seg] && !ret_hit && !flush |=> alias_vld[$past(ret_seg)]);

  a_r7_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (alias_vld == '0) && !fence_stall);

  a_r7_flush_block: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> in_ready == '0);

  a_r8_stall_block: assert property (@(posedge clk) disable iff (!rst_n)
    fence_stall |-> in_ready == '0);

  a_r9_fence_lane: assert property (@(posedge clk) disable iff (!rst_n)
    fence_mode && in_valid[0] && in_wr[0] |-> !in_ready[1]);

  a_r10_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !fence_mode && !fence_stall |=> !fence_stall);
endmodule

bind seg_rename seg_rename_chk #(.LANES(LANES), .TAG_W(TAG_W), .SEG_W(SEG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fence_mode  (fence_mode),
  .flush       (flush),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_wr       (in_wr),
  .in_dst_seg  (in_dst_seg),
  .ret_valid   (ret_valid),
  .ret_seg     (ret_seg),
  .ret_tag     (ret_tag),
  .ret_value   (ret_value),
  .fence_stall (fence_stall),
  .alias_vld   (alias_vld),
  .alias_tags  (alias_tags),
  .arch_flat   (arch_flat)
);

// File: tb/seg_rename_tb.sv
module seg_rename_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 2;
  localparam int TAG_W = 5;
  localparam int SEG_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fence_mode = 1'b0, flush = 1'b0;
  logic [LANES-1:0] in_valid = '0, in_wr = '0;
  logic [2*LANES-1:0] in_src_seg = '0, in_dst_seg = '0;
  logic [LANES*TAG_W-1:0] in_tag = '0;
  logic [LANES-1:0] in_ready, out_valid, out_alias;
  logic [LANES*TAG_W-1:0] out_tag;
  logic [LANES*SEG_W-1:0] out_value;
  logic ret_valid = 1'b0, cmpl_valid = 1'b0;
  logic [1:0] ret_seg = '0;
  logic [TAG_W-1:0] ret_tag = '0, cmpl_tag = '0;
  logic [SEG_W-1:0] ret_value = '0;
  logic fence_stall;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_rename #(.LANES(LANES), .TAG_W(TAG_W), .SEG_W(SEG_W)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  bit m_av [4];
  int m_at [4];
  int m_arch [4];
  bit m_stall;
  int m_ftag;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int seg_of(logic [2*LANES-1:0] v, int i);
    return int'(v[2*i +: 2]);
  endfunction
  function automatic int tag_of(int i);
    return int'(in_tag[TAG_W*i +: TAG_W]);
  endfunction

  // compare outputs before the edge, then advance model at the edge
  task automatic step();
    bit r0, r1, a0, a1, w0, w1;
    int s1, exp_alias, exp_tag;
    #1;
    w0 = in_wr[0]; w1 = in_wr[1];
    r0 = !m_stall && !flush;
    r1 = r0 && !(fence_mode && in_valid[0] && w0);
    a0 = in_valid[0] && r0;
    a1 = in_valid[1] && r1;
    chk(fence_mode ? "R8" : "R10", int'(in_ready[0]), int'(r0));
    chk(fence_mode ? "R9" : "R10", int'(in_ready[1]), int'(r1));
    chk("R11", int'(out_valid), int'({a1, a0}));
    chk(fence_mode ? "R8" : "R10", int'(fence_stall), int'(m_stall));
    if (a0) begin
      exp_alias = m_av[seg_of(in_src_seg, 0)];
      exp_tag   = exp_alias ? m_at[seg_of(in_src_seg, 0)] : 0;
      chk("R2", int'(out_alias[0]), exp_alias);
      chk("R3", int'(out_tag[TAG_W-1:0]), exp_tag);
      chk("R5", int'(out_value[SEG_W-1:0]), m_arch[seg_of(in_src_seg, 0)]);
    end
    if (a1) begin
      s1 = seg_of(in_src_seg, 1);
      if (a0 && w0 && seg_of(in_dst_seg, 0) == s1) begin
        chk("R4", int'(out_alias[1]), 1);
        chk("R4", int'(out_tag[2*TAG_W-1:TAG_W]), tag_of(0));
      end else begin
        exp_alias = m_av[s1];
        exp_tag   = exp_alias ? m_at[s1] : 0;
        chk("R2", int'(out_alias[1]), exp_alias);
        chk("R3", int'(out_tag[2*TAG_W-1:TAG_W]), exp_tag);
      end
      chk("R5", int'(out_value[2*SEG_W-1:SEG_W]), m_arch[s1]);
    end
    @(posedge clk);
    if (ret_valid) m_arch[ret_seg] = int'(ret_value);
    if (flush) begin
      for (int s = 0; s < 4; s++) m_av[s] = 0;
      m_stall = 0;
    end else begin
      if (ret_valid && m_av[ret_seg] && m_at[ret_seg] == int'(ret_tag)) m_av[ret_seg] = 0;
      if (a0 && w0) begin m_av[seg_of(in_dst_seg,0)] = 1; m_at[seg_of(in_dst_seg,0)] = tag_of(0); end
      if (a1 && w1) begin m_av[seg_of(in_dst_seg,1)] = 1; m_at[seg_of(in_dst_seg,1)] = tag_of(1); end
      if (fence_mode && ((a0 && w0) || (a1 && w1))) begin
        m_stall = 1;
        m_ftag  = (a1 && w1) ? tag_of(1) : tag_of(0);
      end else if (m_stall && cmpl_valid && int'(cmpl_tag) == m_ftag) m_stall = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = '0; in_wr = '0; flush = 0; ret_valid = 0; cmpl_valid = 0;
  endtask

  task automatic rand_cycle(bit fm);
    fence_mode = fm;
    in_valid[0] = ($urandom % 4) != 0;
    in_valid[1] = in_valid[0] && ($urandom % 2);
    in_wr       = LANES'($urandom);
    in_src_seg  = 4'($urandom);
    in_dst_seg  = 4'($urandom);
    in_tag      = 10'($urandom);
    flush       = ($urandom % 32) == 0;
    ret_valid   = ($urandom % 3) == 0;
    ret_seg     = 2'($urandom);
    ret_tag     = ($urandom % 2) ? TAG_W'(m_at[ret_seg]) : TAG_W'($urandom);
    ret_value   = SEG_W'($urandom);
    cmpl_valid  = m_stall && ($urandom % 3) == 0;
    cmpl_tag    = ($urandom % 2) ? TAG_W'(m_ftag) : TAG_W'($urandom);
    step();
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin m_av[s] = 0; m_at[s] = 0; m_arch[s] = 0; end
    m_stall = 0; m_ftag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, every segment looked up in both lanes
    for (int s = 0; s < 4; s++) begin
      idle(); in_valid = 2'b11; in_src_seg = {2'(s), 2'(s)};
      #1;
      chk("R1", int'(in_ready), 3);
      chk("R1", int'(fence_stall), 0);
      chk("R1", int'(out_alias), 0);
      chk("R1", int'(out_value), 0);
      step();
    end
    // R3 same-cycle double write: lane 1 wins
    idle(); in_valid = 2'b11; in_wr = 2'b11; in_dst_seg = {2'd2, 2'd2};
    in_tag = {5'd9, 5'd4}; step();
    idle(); in_valid = 2'b01; in_src_seg = 4'd2; #1;
    chk("R3", int'(out_tag[TAG_W-1:0]), 9);
    step();
    // R6: stale retire leaves alias, matching one clears
    idle(); ret_valid = 1; ret_seg = 2; ret_tag = 4; ret_value = 16'h1234; step();
    idle(); in_valid = 2'b01; in_src_seg = 4'd2; #1;
    chk("R6", int'(out_alias[0]), 1);
    chk("R5", int'(out_value[SEG_W-1:0]), 16'h1234);
    step();
    idle(); ret_valid = 1; ret_seg = 2; ret_tag = 9; ret_value = 16'h5678; step();
    idle(); in_valid = 2'b01; in_src_seg = 4'd2; #1;
    chk("R6", int'(out_alias[0]), 0);
    step();
    // R7: flush drops aliases
    idle(); in_valid = 2'b01; in_wr = 2'b01; in_dst_seg = 4'd1; in_tag = 10'd3; step();
    idle(); flush = 1; in_valid = 2'b01; #1;
    chk("R7", int'(in_ready), 0);
    step();
    idle(); in_valid = 2'b01; in_src_seg = 4'd1; #1;
    chk("R7", int'(out_alias[0]), 0);
    step();
    // R8/R9: fence, lane 1 blocked, wrong completion ignored
    idle(); fence_mode = 1; in_valid = 2'b11; in_wr = 2'b01; in_dst_seg = 4'd0;
    in_tag = {5'd7, 5'd6}; step();
    idle(); cmpl_valid = 1; cmpl_tag = 5'd7; step();
    idle(); #1;
    chk("R8", int'(fence_stall), 1);
    step();
    idle(); cmpl_valid = 1; cmpl_tag = 5'd6; step();
    idle(); #1;
    chk("R8", int'(fence_stall), 0);
    step();
    // random sweeps in both modes
    for (int n = 0; n < 3000; n++) rand_cycle(1'b0);
    for (int n = 0; n < 3000; n++) rand_cycle(1'b1);
    idle(); fence_mode = 0; flush = 1; step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule